// File: doc/BRIEF.md
# Slow-Infrared Frame Transmit Encoder

This block sends packets over a slow-rate infrared link. Payload bytes arrive on a valid/ready stream. Each packet goes out wrapped between a configurable opening flag byte and a configurable closing flag byte. Every character is serialised the way a UART would do it, and the result is turned into return-to-zero infrared pulses: a zero bit becomes a short high pulse at the start of its bit cell, and a one bit leaves the line dark. The bit rate, the pulse width and the two flag bytes sit in a four-byte configuration space written through a plain strobe port. A separate pin inverts the output polarity so the block can drive transceivers with either sense.

Timing is built from a 16x tick. The tick is `CLKS_PER_TICK` clocks long, and nominally it runs at 16 times 115200 Hz. A bit cell is 16 × (divisor + 1) ticks, so the rate is 115200 / (divisor + 1). A divisor of 0 gives 115200, 1 gives 57600, 2 gives 38400, 5 gives 19200, 11 gives 9600 and 47 gives 2400. Back-pressure works as follows. A packet begins when `s_valid` rises while the block is idle, but that byte is not taken until BOF has gone out. After that, `s_ready` is high only during the load cycle between characters. If the source holds `s_valid` low at that point, the line stays at its idle level and `busy` stays high until a byte is offered. `s_data` and `s_last` must be held while `s_valid` is high and not yet accepted.

Top module: `sir_tx_enc`

## Requirements
- R1: After reset, `ir_tx`, `busy` and `s_ready` are 0. The configuration holds an opening flag of 0xC0, a closing flag of 0xC1, a pulse width of 3 and a divisor of 0.
- R2: A configuration write (`cfg_we` high at a clock edge) decodes `cfg_addr` as follows. Address 0 sets the opening flag. Address 1 sets the closing flag. Address 2 bits 7:5 set pulse width bits 2:0. Address 3 bits 7:2 set the 6-bit divisor, and address 3 bits 1:0 set pulse width bits 4:3.
- R3: A packet goes out as the opening flag, then each payload byte in acceptance order, then the closing flag. The payload ends with the byte that carried `s_last`.
- R4: Each character is 10 bit cells: a start bit of 0, eight data bits with the least significant bit first, and a stop bit of 1.
- R5: A bit cell lasts 16 × (divisor + 1) ticks, and a tick lasts `CLKS_PER_TICK` clocks.
- R6: A zero bit drives the line high from the first tick of its cell for as many ticks as the pulse width, clipped to the cell. A one bit, a pulse width of 0 and the idle line all stay low.
- R7: With `tx_invert` high, `ir_tx` is the complement of the uninverted line, including when idle.
- R8: `s_ready` is high only in the one load cycle that follows the opening flag or a payload character, and never before the closing flag. If `s_valid` is low in that cycle, the load state holds with the line idle until `s_valid` rises. Each character begins on the cycle after its load cycle.
- R9: `busy` goes high on the clock edge that sees `s_valid` while idle. It goes low on the edge that ends the stop bit of the closing flag. `ir_tx` is registered and follows the internal line level one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration byte select |
| cfg_wdata | input | 8 | Configuration write data |
| tx_invert | input | 1 | Output polarity inversion |
| s_valid | input | 1 | Payload byte valid |
| s_data | input | 8 | Payload byte |
| s_last | input | 1 | Marks the final payload byte |
| s_ready | output | 1 | Payload byte accepted at this edge when valid |
| busy | output | 1 | A packet is in progress |
| ir_tx | output | 1 | Infrared transmit line |

## Verification
The hardest condition to reach from the ports is a stalled load cycle in the middle of a packet. In that state the framer has finished a character and is waiting for the source, so the line must stay dark and `busy` must stay high. The stimulus reaches it by dropping `s_valid` on the exact cycle in which `s_ready` is first seen after the opening flag, and holding it low for a fixed count. The bench's arithmetic line model inserts the same number of idle cycles. Pulse clipping at the shortest cell is reached by combining divisor 0 with pulse widths of 16 and 31.

// File: rtl/sir_tx_pkg.sv
package sir_tx_pkg;
  localparam int DIV_W        = 6;
  localparam int PW_W         = 5;
  localparam int CHAR_BITS    = 10;
  localparam int BIDX_W       = 4;
  localparam int TICKS_PER_UNIT = 16;

  localparam logic [7:0]       OPEN_FLAG_RST  = 8'hC0;
  localparam logic [7:0]       CLOSE_FLAG_RST = 8'hC1;
  localparam logic [PW_W-1:0]  PW_RST         = 5'd3;
  localparam logic [DIV_W-1:0] DIV_RST        = 6'd0;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_LOAD = 2'd2
  } tx_state_e;

  typedef enum logic [1:0] {
    CH_OPEN  = 2'd0,
    CH_DATA  = 2'd1,
    CH_CLOSE = 2'd2
  } char_kind_e;
endpackage

// File: rtl/sir_tx_cfg.sv
module sir_tx_cfg
  import sir_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       open_flag,
  output logic [7:0]       close_flag,
  output logic [DIV_W-1:0] div,
  output logic [PW_W-1:0]  pw
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_flag  <= OPEN_FLAG_RST;
      close_flag <= CLOSE_FLAG_RST;
      div        <= DIV_RST;
      pw         <= PW_RST;
    end else if (we) begin
      case (addr)
        2'd0: open_flag  <= wdata;
        2'd1: close_flag <= wdata;
        2'd2: pw[2:0]    <= wdata[7:5];
        default: begin
          div     <= wdata[7:2];
          pw[4:3] <= wdata[1:0];
        end
      endcase
    end
  end
endmodule

// File: rtl/sir_tx_prescale.sv
module sir_tx_prescale #(
  parameter int CLKS_PER_TICK = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  generate
    if (CLKS_PER_TICK <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_count
      localparam int CW = $clog2(CLKS_PER_TICK);
      localparam logic [CW-1:0] CMAX = CW'(CLKS_PER_TICK - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (!run)       cnt <= '0;
        else if (cnt == CMAX) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
      end
      assign tick = run && (cnt == CMAX);
    end
  endgenerate
endmodule

// File: rtl/sir_tx_framer.sv
module sir_tx_framer
  import sir_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [DIV_W-1:0] div,
  input  logic [PW_W-1:0]  pw,
  input  logic [7:0]       open_flag,
  input  logic [7:0]       close_flag,
  input  logic             s_valid,
  input  logic [7:0]       s_data,
  input  logic             s_last,
  output logic             s_ready,
  output logic             busy,
  output logic             run,
  output logic             pulse_req
);
  localparam int TCNT_W = DIV_W + 4;
  localparam logic [BIDX_W-1:0] LAST_BIT = BIDX_W'(CHAR_BITS - 1);

  tx_state_e         state;
  char_kind_e        kind;
  logic              last_q;
  logic [7:0]        char_q;
  logic [BIDX_W-1:0] bidx;
  logic [TCNT_W-1:0] tcnt;

  logic [TCNT_W-1:0] cell_max;
  logic [2:0]        dsel;
  logic              cur_bit;
  logic              close_next;

  // last tick index of a cell: (div+1)*16-1
  assign cell_max   = {div, 4'hF};
  assign dsel       = bidx[2:0] - 3'd1;
  assign cur_bit    = (bidx == '0)       ? 1'b0 :
                      (bidx == LAST_BIT) ? 1'b1 : char_q[dsel];
  assign close_next = (kind == CH_DATA) && last_q;

  assign run       = (state == ST_SEND);
  assign busy      = (state != ST_IDLE);
  assign s_ready   = (state == ST_LOAD) && !close_next;
  assign pulse_req = run && !cur_bit && (tcnt < TCNT_W'(pw));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      kind   <= CH_OPEN;
      last_q <= 1'b0;
      char_q <= '0;
      bidx   <= '0;
      tcnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (s_valid) begin
            state  <= ST_SEND;
            kind   <= CH_OPEN;
            char_q <= open_flag;
            bidx   <= '0;
            tcnt   <= '0;
          end
        end
        ST_SEND: begin
          if (tick) begin
            if (tcnt == cell_max) begin
              tcnt <= '0;
              if (bidx == LAST_BIT) begin
                bidx  <= '0;
                state <= (kind == CH_CLOSE) ? ST_IDLE : ST_LOAD;
              end else begin
                bidx <= bidx + 1'b1;
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        ST_LOAD: begin
          if (close_next) begin
            kind   <= CH_CLOSE;
            char_q <= close_flag;
            state  <= ST_SEND;
          end else if (s_valid) begin
            kind   <= CH_DATA;
            char_q <= s_data;
            last_q <= s_last;
            state  <= ST_SEND;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sir_tx_line.sv
module sir_tx_line (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_req,
  input  logic invert,
  output logic ir_tx
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ir_tx <= 1'b0;
    else        ir_tx <= pulse_req ^ invert;
  end
endmodule

// File: rtl/sir_tx_enc.sv
module sir_tx_enc
  import sir_tx_pkg::*;
#(
  parameter int CLKS_PER_TICK = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  input  logic       tx_invert,
  input  logic       s_valid,
  input  logic [7:0] s_data,
  input  logic       s_last,
  output logic       s_ready,
  output logic       busy,
  output logic       ir_tx
);
  logic [7:0]       open_w, close_w;
  logic [DIV_W-1:0] div_w;
  logic [PW_W-1:0]  pw_w;
  logic             tick_w, run_w, pulse_w;

  sir_tx_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .open_flag(open_w), .close_flag(close_w), .div(div_w), .pw(pw_w)
  );

  sir_tx_prescale #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run_w), .tick(tick_w)
  );

  sir_tx_framer u_frm (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .div(div_w), .pw(pw_w),
    .open_flag(open_w), .close_flag(close_w),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
    .s_ready(s_ready), .busy(busy), .run(run_w), .pulse_req(pulse_w)
  );

  sir_tx_line u_line (
    .clk(clk), .rst_n(rst_n), .pulse_req(pulse_w), .invert(tx_invert), .ir_tx(ir_tx)
  );
endmodule

// File: rtl/sir_tx_enc_chk.sv
module sir_tx_enc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       s_valid,
  input logic       s_ready,
  input logic       busy,
  input logic       ir_tx,
  input logic       invert,
  input logic [4:0] pw
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  // R8
  ready_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> busy);

  // R8
  accept_leaves_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready && busy);

  // R9
  start_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(s_valid));

  // R7
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !busy && $past(!busy) && $stable(invert)) |-> (ir_tx == invert));

  // R6
  no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && pw == 5'd0 && $stable(pw) && $stable(invert)) |-> (ir_tx == invert));
endmodule

bind sir_tx_enc sir_tx_enc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .busy(busy), .ir_tx(ir_tx), .invert(tx_invert), .pw(pw_w)
);

// File: tb/sir_tx_enc_tb.sv
module sir_tx_enc_tb;
  localparam int TICK = 2;
  localparam int DEPTH = 8192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic tx_invert = 1'b0;
  logic s_valid = 1'b0;
  logic [7:0] s_data = '0;
  logic s_last = 1'b0;
  logic s_ready, busy, ir_tx;

  always #5 clk = ~clk;

  sir_tx_enc #(.CLKS_PER_TICK(TICK)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tx_invert(tx_invert), .s_valid(s_valid),
    .s_data(s_data), .s_last(s_last), .s_ready(s_ready), .busy(busy), .ir_tx(ir_tx)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  logic [7:0] pay [0:3];
  logic smp_line [0:DEPTH-1];
  logic smp_busy [0:DEPTH-1];

  int e_div, e_pw, e_n, e_stall;
  logic [7:0] e_open, e_close;

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      n_fail++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // Expected uninverted line level, k clocks after the start edge
  function automatic logic exp_raw(input int kin);
    int c, per, k, j, r, b, tk;
    logic [7:0] ch;
    logic bit_v;
    k   = kin;
    c   = 16 * (e_div + 1) * TICK;
    per = 10 * c + 1;
    if (e_stall > 0 && k >= 10 * c) begin
      if (k < 10 * c + e_stall) return 1'b0;
      k = k - e_stall;
    end
    j = k / per;
    r = k % per;
    if (r >= 10 * c) return 1'b0;
    b  = r / c;
    tk = (r % c) / TICK;
    if (j == 0)        ch = e_open;
    else if (j <= e_n) ch = pay[j-1];
    else               ch = e_close;
    bit_v = (b == 0) ? 1'b0 : (b == 9) ? 1'b1 : ch[b-1];
    return (!bit_v) && (tk < e_pw);
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_frame(input int dv, input int pwv, input logic inv, input int n,
                           input int stall, input logic do_cfg,
                           input logic [7:0] ov, input logic [7:0] cv, input string tag);
    int c, per, len, lim, tb0, hs, scnt, mism, first_bad;
    logic pend, stalled, expv;
    if (do_cfg) begin
      wr(2'd0, ov);
      wr(2'd1, cv);
      wr(2'd2, {pwv[2:0], 5'b10101});
      wr(2'd3, {dv[5:0], pwv[4:3]});
    end
    e_div = dv; e_pw = pwv; e_n = n; e_stall = stall; e_open = ov; e_close = cv;
    c   = 16 * (dv + 1) * TICK;
    per = 10 * c + 1;
    len = (n + 2) * per - 1 + stall;
    lim = len + stall + 40;
    @(negedge clk);
    tx_invert = inv;
    @(negedge clk);
    @(negedge clk);
    s_valid = 1'b1; s_data = pay[0]; s_last = (n == 1);
    hs = 0; pend = 1'b0; stalled = 1'b0; scnt = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      smp_line[i] = ir_tx;
      smp_busy[i] = busy;
      if (pend) begin
        hs++;
        if (hs < n) begin s_data = pay[hs]; s_last = (hs == n - 1); end
        else s_valid = 1'b0;
        pend = 1'b0;
      end
      if (stall > 0 && !stalled && s_ready && hs == 0) begin
        s_valid = 1'b0; scnt = stall; stalled = 1'b1;
      end else if (scnt > 0) begin
        scnt--;
        if (scnt == 0) s_valid = 1'b1;
      end
      pend = s_valid && s_ready;
    end
    tb0 = -1;
    for (int i = 0; i < lim; i++) if (tb0 < 0 && smp_busy[i]) tb0 = i;
    chk(tb0 >= 0, "R9", {tag, " busy rises"}, tb0, 0);
    if (tb0 < 0) tb0 = 0;
    mism = 0; first_bad = -1;
    for (int k = 0; k < len + 5; k++) begin
      expv = ((k < len) ? exp_raw(k) : 1'b0) ^ inv;
      if (smp_line[tb0 + 1 + k] !== expv) begin
        mism++;
        if (first_bad < 0) first_bad = k;
      end
    end
    // R3 R4 R5 R6 R7 R8 R9: full line comparison
    chk(mism == 0, "R3 R4 R5 R6 R7", {tag, " line mismatches (first at k)"}, first_bad, -1);
    chk(smp_busy[tb0 + len - 1] === 1'b1, "R9", {tag, " busy through closing stop bit"},
        int'(smp_busy[tb0 + len - 1]), 1);
    chk(smp_busy[tb0 + len] === 1'b0, "R9", {tag, " busy drops after closing flag"},
        int'(smp_busy[tb0 + len]), 0);
    chk(hs == n, "R8", {tag, " bytes accepted"}, hs, n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ir_tx === 1'b0 && busy === 1'b0 && s_ready === 1'b0, "R1", "outputs in reset",
        int'({ir_tx, busy, s_ready}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ir_tx === 1'b0 && busy === 1'b0 && s_ready === 1'b0, "R1", "outputs after reset",
        int'({ir_tx, busy, s_ready}), 0);

    // R1: default configuration frame, payload with all-zero and all-one bytes
    pay[0] = 8'h00; pay[1] = 8'hFF; pay[2] = 8'h3C; pay[3] = 8'h81;
    run_frame(0, 3, 1'b0, 2, 0, 1'b0, 8'hC0, 8'hC1, "R1 defaults");

    // R2 R5 R6 R7: sweep of divisor, pulse width and polarity
    begin
      int idx;
      int pws [0:3];
      pws[0] = 0; pws[1] = 3; pws[2] = 16; pws[3] = 31;
      idx = 0;
      for (int d = 0; d < 3; d++) begin
        for (int p = 0; p < 4; p++) begin
          pay[0] = 8'(idx * 37 + 5);
          pay[1] = 8'(idx * 91 + 200);
          run_frame(d, pws[p], logic'(idx % 2), 2, 0, 1'b1,
                    8'(8'hA5 ^ idx), 8'(8'h5A + idx), "R2 sweep");
          idx++;
        end
      end
    end

    // R8: source stalls in the first load cycle
    pay[0] = 8'h96; pay[1] = 8'h01; pay[2] = 8'h80;
    run_frame(0, 3, 1'b0, 3, 37, 1'b1, 8'hC0, 8'hC1, "R8 stall");

    // R5: divisor 5 (19200 rate), single byte, inverted
    pay[0] = 8'h55;
    run_frame(5, 5, 1'b1, 1, 0, 1'b1, 8'h7E, 8'hE7, "R5 div5");

    // R7: idle inverted level
    @(negedge clk);
    chk(ir_tx === 1'b1 && busy === 1'b0, "R7", "inverted idle level", int'(ir_tx), 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule